// File: doc/BRIEF.md
# Masked-Compare Fully Associative TLB

This block is a small translation lookaside buffer. Every slot can be compared in one cycle. Each slot stores the following fields:

- a virtual page number
- a page-size mask
- an address-space tag
- a global flag
- two valid bits
- a physical frame number

A set bit in a slot's mask removes that page-number bit from the compare, so one slot can cover a larger page. The global flag makes a slot match under any address-space tag.

The block has several ways to use the table:

- **Lookup port:** returns a registered hit, slot index, frame number and valid bits one cycle after a request.
- **Probe port:** reports combinationally which slot matches, or gives a not-found code.
- **Write port:** software loads a slot at a chosen index.
- **Flush:** clears the whole table.
- **Replacement pointer:** points at the next slot and shows that slot's contents. An advance input steps it forward.
- **Uncacheable flag:** a separate combinational output marks addresses that fall in the uncacheable window.

Top module: `tlbm_top`

## Requirements
- R1: A slot matches a page number when the two agree on every bit where the slot's mask is 0; bits where the mask is 1 are not compared.
- R2: A match also needs the slot's global flag set or its stored address-space tag equal to the requested one.
- R3: When several slots match, the lowest slot index is reported, on both lookup and probe.
- R4: A slot takes part in matching only when at least one of its two valid bits (`vbits[1]`, `vbits[0]`) is 1.
- R5: Probe outputs: `pr_found`=1 and `pr_idx`=slot on a match; `pr_found`=0 and `pr_idx` all ones otherwise.
- R6: A write with `wr_idx` below the table size replaces that whole slot at the clock edge. A write with `wr_idx` at or above the table size changes nothing, and `wr_warn` is 1 for the single following cycle.
- R7: Flush clears every slot field, including the valid bits, and sets the replacement pointer to 0. It wins over a write in the same cycle. Reset gives the same state.
- R8: `uc_flag` is 1 exactly when every bit set in 0xA0000000 is also set in `uc_vaddr`.
- R9: `ix_idx` and `ix_vpn`/`ix_pfn`/`ix_vbits` show the pointer and the slot it selects. With `ix_adv` high the pointer steps by one at the edge and wraps from the last slot to 0.
- R10: After an edge where `lk_valid` is 1, `lk_hit`, `lk_idx`, `lk_pfn` and `lk_vbits` hold the result for the table state before that edge. A miss gives hit 0, index all ones, frame 0 and vbits 0. After an edge with `lk_valid` at 0, `lk_hit` is 0 and the other three fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_hit | output | 1 | Registered lookup hit |
| lk_idx | output | IDX_W | Registered matching slot |
| lk_pfn | output | PFN_W | Registered frame number |
| lk_vbits | output | 2 | Registered valid bits of the match |
| pr_vpn | input | VPN_W | Probe page number |
| pr_asid | input | ASID_W | Probe address-space tag |
| pr_found | output | 1 | Probe match flag |
| pr_idx | output | IDX_W | Probe slot, all ones if none |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W+1 | Slot index to write |
| wr_vpn | input | VPN_W | Page number to store |
| wr_mask | input | VPN_W | Page-size mask to store |
| wr_asid | input | ASID_W | Address-space tag to store |
| wr_glob | input | 1 | Global flag to store |
| wr_vbits | input | 2 | Valid bits to store |
| wr_pfn | input | PFN_W | Frame number to store |
| wr_warn | output | 1 | One-cycle pulse after an out-of-range write |
| flush | input | 1 | Clear all slots and pointer |
| ix_adv | input | 1 | Advance the replacement pointer |
| ix_idx | output | IDX_W | Replacement pointer |
| ix_vpn | output | VPN_W | Page number at the pointer |
| ix_pfn | output | PFN_W | Frame number at the pointer |
| ix_vbits | output | 2 | Valid bits at the pointer |
| uc_vaddr | input | VA_W | Address for the uncacheable test |
| uc_flag | output | 1 | Address lies in the uncacheable window |

## Verification
The bench aims lookups and probes at slots chosen to separate the match conditions:

- **Exact-compare slots:** catch a mask that is ignored or inverted.
- **Masked slots:** hit only when the low bits are don't-care.
- **Slots reached through the global flag, and the same page under a foreign tag:** isolate the address-space term.
- **A slot holding only the second valid bit, and a cleared slot:** test the valid OR.
- **Two overlapping slots:** expose the wrong priority direction.

Out-of-range write indices, flush issued together with a write, seventeen pointer advances, and uncacheable addresses with one window bit missing cover the edges of the write, flush, pointer and uncacheable functions. A long stretch of pseudo-random lookups and probes then runs against the behavioural table model.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam logic [31:0] UC_WINDOW = 32'hA000_0000;
  typedef logic [1:0] vbits_t;
endpackage

// File: rtl/tlbm_store.sv
module tlbm_store #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  localparam int IDX_W  = $clog2(N),
  localparam int WIDX_W = IDX_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [WIDX_W-1:0]             wr_idx,
  input  logic [VPN_W-1:0]              wr_vpn,
  input  logic [VPN_W-1:0]              wr_mask,
  input  logic [ASID_W-1:0]             wr_asid,
  input  logic                          wr_glob,
  input  tlbm_pkg::vbits_t              wr_vbits,
  input  logic [PFN_W-1:0]              wr_pfn,
  input  logic                          flush,
  output logic [N-1:0][VPN_W-1:0]       ent_vpn,
  output logic [N-1:0][VPN_W-1:0]       ent_mask,
  output logic [N-1:0][ASID_W-1:0]      ent_asid,
  output logic [N-1:0]                  ent_glob,
  output tlbm_pkg::vbits_t [N-1:0]      ent_vbits,
  output logic [N-1:0][PFN_W-1:0]       ent_pfn,
  output logic [N-1:0]                  ent_vld,
  output logic                          wr_warn
);
  logic wr_ok, upd_en, warn_d;
  logic [N-1:0][VPN_W-1:0]  vpn_d, mask_d;
  logic [N-1:0][ASID_W-1:0] asid_d;
  logic [N-1:0]             glob_d;
  tlbm_pkg::vbits_t [N-1:0] vb_d;
  logic [N-1:0][PFN_W-1:0]  pfn_d;

  assign wr_ok  = wr_en && (wr_idx < WIDX_W'(N));
  assign upd_en = flush || wr_ok;
  assign warn_d = wr_en && !wr_ok;

  always_comb begin
    vpn_d  = ent_vpn;
    mask_d = ent_mask;
    asid_d = ent_asid;
    glob_d = ent_glob;
    vb_d   = ent_vbits;
    pfn_d  = ent_pfn;
    if (flush) begin
      vpn_d  = '0;
      mask_d = '0;
      asid_d = '0;
      glob_d = '0;
      vb_d   = '0;
      pfn_d  = '0;
    end else if (wr_ok) begin
      vpn_d[wr_idx[IDX_W-1:0]]  = wr_vpn;
      mask_d[wr_idx[IDX_W-1:0]] = wr_mask;
      asid_d[wr_idx[IDX_W-1:0]] = wr_asid;
      glob_d[wr_idx[IDX_W-1:0]] = wr_glob;
      vb_d[wr_idx[IDX_W-1:0]]   = wr_vbits;
      pfn_d[wr_idx[IDX_W-1:0]]  = wr_pfn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vpn   <= '0;
      ent_mask  <= '0;
      ent_asid  <= '0;
      ent_glob  <= '0;
      ent_vbits <= '0;
      ent_pfn   <= '0;
    end else if (upd_en) begin
      ent_vpn   <= vpn_d;
      ent_mask  <= mask_d;
      ent_asid  <= asid_d;
      ent_glob  <= glob_d;
      ent_vbits <= vb_d;
      ent_pfn   <= pfn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_warn <= 1'b0;
    else        wr_warn <= warn_d;
  end

  for (genvar g = 0; g < N; g++) begin : g_vld
    assign ent_vld[g] = |ent_vbits[g];
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_vld == '0)); // R7
  AST_BAD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= WIDX_W'(N)) && !flush) |=> ($stable(ent_vld) && $stable(ent_vpn))); // R6
  AST_WARN_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_warn |-> $past(wr_en)); // R6
endmodule

// File: rtl/tlbm_match.sv
module tlbm_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [VPN_W-1:0]              q_vpn,
  input  logic [ASID_W-1:0]             q_asid,
  input  logic [N-1:0][VPN_W-1:0]       ent_vpn,
  input  logic [N-1:0][VPN_W-1:0]       ent_mask,
  input  logic [N-1:0][ASID_W-1:0]      ent_asid,
  input  logic [N-1:0]                  ent_glob,
  input  tlbm_pkg::vbits_t [N-1:0]      ent_vbits,
  input  logic [N-1:0][PFN_W-1:0]       ent_pfn,
  input  logic [N-1:0]                  ent_vld,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx,
  output logic [PFN_W-1:0]              pfn,
  output tlbm_pkg::vbits_t              vbits
);
  logic [N-1:0] cand;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic page_eq, tag_ok;
    assign page_eq = (((q_vpn ^ ent_vpn[g]) & ~ent_mask[g]) == '0);
    assign tag_ok  = ent_glob[g] || (ent_asid[g] == q_asid);
    assign cand[g] = ent_vld[g] && page_eq && tag_ok;
  end

  always_comb begin
    hit   = 1'b0;
    idx   = '1;
    pfn   = '0;
    vbits = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit   = 1'b1;
        idx   = IDX_W'(i);
        pfn   = ent_pfn[i];
        vbits = ent_vbits[i];
      end
    end
  end
endmodule

// File: rtl/tlbm_nextptr.sv
module tlbm_nextptr #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] ptr_d;
  logic             ptr_en;

  assign ptr_en = flush || adv;

  always_comb begin
    if (flush)                      ptr_d = '0;
    else if (ptr == IDX_W'(N - 1))  ptr_d = '0;
    else                            ptr_d = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_d;
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !flush && ptr == IDX_W'(N - 1)) |=> (ptr == '0)); // R9
  AST_PTR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ptr == '0)); // R7
endmodule

// File: rtl/tlbm_top.sv
module tlbm_top #(
  parameter int          N          = 16,
  parameter int          VPN_W      = 20,
  parameter int          ASID_W     = 8,
  parameter int          PFN_W      = 20,
  parameter int          VA_W       = 32,
  parameter logic [VA_W-1:0] UC_PATTERN = VA_W'(tlbm_pkg::UC_WINDOW),
  localparam int         IDX_W      = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [1:0]        lk_vbits,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  output logic              pr_found,
  output logic [IDX_W-1:0]  pr_idx,
  input  logic              wr_en,
  input  logic [IDX_W:0]    wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic [1:0]        wr_vbits,
  input  logic [PFN_W-1:0]  wr_pfn,
  output logic              wr_warn,
  input  logic              flush,
  input  logic              ix_adv,
  output logic [IDX_W-1:0]  ix_idx,
  output logic [VPN_W-1:0]  ix_vpn,
  output logic [PFN_W-1:0]  ix_pfn,
  output logic [1:0]        ix_vbits,
  input  logic [VA_W-1:0]   uc_vaddr,
  output logic              uc_flag
);
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  logic [N-1:0][VPN_W-1:0]  ent_vpn, ent_mask;
  logic [N-1:0][ASID_W-1:0] ent_asid;
  logic [N-1:0]             ent_glob, ent_vld;
  tlbm_pkg::vbits_t [N-1:0] ent_vbits;
  logic [N-1:0][PFN_W-1:0]  ent_pfn;

  tlbm_store #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_store (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_vbits(wr_vbits), .wr_pfn(wr_pfn),
    .flush(flush),
    .ent_vpn(ent_vpn), .ent_mask(ent_mask), .ent_asid(ent_asid),
    .ent_glob(ent_glob), .ent_vbits(ent_vbits), .ent_pfn(ent_pfn),
    .ent_vld(ent_vld), .wr_warn(wr_warn)
  );

  // Lookup and probe share one matcher design, instanced per port.
  logic             m_hit   [2];
  logic [IDX_W-1:0] m_idx   [2];
  logic [PFN_W-1:0] m_pfn   [2];
  tlbm_pkg::vbits_t m_vbits [2];
  logic [VPN_W-1:0]  q_vpn  [2];
  logic [ASID_W-1:0] q_asid [2];

  assign q_vpn[0]  = lk_vpn;
  assign q_asid[0] = lk_asid;
  assign q_vpn[1]  = pr_vpn;
  assign q_asid[1] = pr_asid;

  for (genvar p = 0; p < 2; p++) begin : g_port
    tlbm_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_match (
      .q_vpn(q_vpn[p]), .q_asid(q_asid[p]),
      .ent_vpn(ent_vpn), .ent_mask(ent_mask), .ent_asid(ent_asid),
      .ent_glob(ent_glob), .ent_vbits(ent_vbits), .ent_pfn(ent_pfn),
      .ent_vld(ent_vld),
      .hit(m_hit[p]), .idx(m_idx[p]), .pfn(m_pfn[p]), .vbits(m_vbits[p])
    );
  end

  assign pr_found = m_hit[1];
  assign pr_idx   = m_idx[1];

  logic hit_d;
  assign hit_d = lk_valid && m_hit[0];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) lk_hit <= 1'b0;
    else          lk_hit <= hit_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lk_idx   <= '0;
      lk_pfn   <= '0;
      lk_vbits <= '0;
    end else if (lk_valid) begin
      lk_idx   <= m_idx[0];
      lk_pfn   <= m_pfn[0];
      lk_vbits <= m_vbits[0];
    end
  end

  tlbm_nextptr #(.N(N)) u_ptr (
    .clk(clk), .rst_n(rst_n_s), .flush(flush), .adv(ix_adv), .ptr(ix_idx)
  );

  assign ix_vpn   = ent_vpn[ix_idx];
  assign ix_pfn   = ent_pfn[ix_idx];
  assign ix_vbits = ent_vbits[ix_idx];

  assign uc_flag = ((uc_vaddr & UC_PATTERN) == UC_PATTERN);

  AST_LK_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n_s)
    lk_hit |-> $past(lk_valid)); // R10
  AST_LK_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lk_valid |=> ($stable(lk_pfn) && $stable(lk_idx))); // R10
endmodule

// File: tb/tlbm_top_bench.sv
module tlbm_top_bench;
  localparam int N = 16;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic lk_valid; logic [19:0] lk_vpn; logic [7:0] lk_asid;
  logic lk_hit; logic [3:0] lk_idx; logic [19:0] lk_pfn; logic [1:0] lk_vbits;
  logic [19:0] pr_vpn; logic [7:0] pr_asid; logic pr_found; logic [3:0] pr_idx;
  logic wr_en; logic [4:0] wr_idx; logic [19:0] wr_vpn, wr_mask; logic [7:0] wr_asid;
  logic wr_glob; logic [1:0] wr_vbits; logic [19:0] wr_pfn; logic wr_warn;
  logic flush, ix_adv; logic [3:0] ix_idx; logic [19:0] ix_vpn, ix_pfn; logic [1:0] ix_vbits;
  logic [31:0] uc_vaddr; logic uc_flag;

  tlbm_top u_tlbm_top (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pfn(lk_pfn), .lk_vbits(lk_vbits),
    .pr_vpn(pr_vpn), .pr_asid(pr_asid), .pr_found(pr_found), .pr_idx(pr_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_vbits(wr_vbits), .wr_pfn(wr_pfn),
    .wr_warn(wr_warn), .flush(flush), .ix_adv(ix_adv),
    .ix_idx(ix_idx), .ix_vpn(ix_vpn), .ix_pfn(ix_pfn), .ix_vbits(ix_vbits),
    .uc_vaddr(uc_vaddr), .uc_flag(uc_flag)
  );

  int checks = 0, errors = 0;

  // Behavioural reference table
  int m_vpn[N], m_mask[N], m_asid[N], m_glob[N], m_vb[N], m_pfn[N];
  int m_ptr = 0;
  int e_hit = 0, e_idx = 0, e_pfn = 0, e_vb = 0, e_warn = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int mfind(int vpn, int asid);
    for (int i = 0; i < N; i++) begin
      if (m_vb[i] != 0 && ((vpn & ~m_mask[i] & 32'hFFFFF) == (m_vpn[i] & ~m_mask[i] & 32'hFFFFF))
          && (m_glob[i] != 0 || m_asid[i] == asid))
        return i;
    end
    return -1;
  endfunction

  task automatic mclear();
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = 0; m_mask[i] = 0; m_asid[i] = 0; m_glob[i] = 0; m_vb[i] = 0; m_pfn[i] = 0;
    end
    m_ptr = 0;
  endtask

  // One clock: inputs already driven after a falling edge.
  task automatic cyc(string tag);
    int f, n_hit, n_idx, n_pfn, n_vb;
    #1;
    f = mfind(int'(pr_vpn), int'(pr_asid));
    chk(tag, "pr_found", pr_found, (f >= 0) ? 1 : 0);
    chk(tag, "pr_idx", pr_idx, (f >= 0) ? f : 15);
    chk(tag, "ix_idx", ix_idx, m_ptr);
    chk(tag, "ix_vpn", ix_vpn, m_vpn[m_ptr]);
    chk(tag, "ix_pfn", ix_pfn, m_pfn[m_ptr]);
    chk(tag, "ix_vbits", ix_vbits, m_vb[m_ptr]);
    chk(tag, "uc_flag", uc_flag, ((uc_vaddr & 32'hA000_0000) == 32'hA000_0000) ? 1 : 0);
    n_hit = 0; n_idx = e_idx; n_pfn = e_pfn; n_vb = e_vb;
    if (lk_valid) begin
      f = mfind(int'(lk_vpn), int'(lk_asid));
      n_hit = (f >= 0) ? 1 : 0;
      n_idx = (f >= 0) ? f : 15;
      n_pfn = (f >= 0) ? m_pfn[f] : 0;
      n_vb  = (f >= 0) ? m_vb[f] : 0;
    end
    @(posedge clk);
    e_hit = n_hit; e_idx = n_idx; e_pfn = n_pfn; e_vb = n_vb;
    e_warn = (wr_en && wr_idx >= 5'(N)) ? 1 : 0;
    if (flush) mclear();
    else begin
      if (wr_en && wr_idx < 5'(N)) begin
        m_vpn[wr_idx] = int'(wr_vpn); m_mask[wr_idx] = int'(wr_mask);
        m_asid[wr_idx] = int'(wr_asid); m_glob[wr_idx] = int'(wr_glob);
        m_vb[wr_idx] = int'(wr_vbits); m_pfn[wr_idx] = int'(wr_pfn);
      end
      if (ix_adv) m_ptr = (m_ptr + 1) % N;
    end
    @(negedge clk);
    chk(tag, "lk_hit", lk_hit, e_hit);
    chk(tag, "lk_idx", lk_idx, e_idx);
    chk(tag, "lk_pfn", lk_pfn, e_pfn);
    chk(tag, "lk_vbits", lk_vbits, e_vb);
    chk(tag, "wr_warn", wr_warn, e_warn);
  endtask

  task automatic wr(string tag, int idx, int vpn, int mask, int asid, int g, int vb, int pfn);
    wr_en = 1; wr_idx = 5'(idx); wr_vpn = 20'(vpn); wr_mask = 20'(mask);
    wr_asid = 8'(asid); wr_glob = g[0]; wr_vbits = 2'(vb); wr_pfn = 20'(pfn);
    cyc(tag);
    wr_en = 0;
  endtask

  task automatic look(string tag, int vpn, int asid);
    lk_valid = 1; lk_vpn = 20'(vpn); lk_asid = 8'(asid);
    pr_vpn = 20'(vpn); pr_asid = 8'(asid);
    cyc(tag);
    lk_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL all watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lf;
    rst_n = 0; lk_valid = 0; lk_vpn = 0; lk_asid = 0; pr_vpn = 0; pr_asid = 0;
    wr_en = 0; wr_idx = 0; wr_vpn = 0; wr_mask = 0; wr_asid = 0; wr_glob = 0;
    wr_vbits = 0; wr_pfn = 0; flush = 0; ix_adv = 0; uc_vaddr = 0;
    mclear();
    repeat (3) @(negedge clk);
    // Reset state (R7, R10)
    chk("R10", "reset lk_hit", lk_hit, 0);
    chk("R6", "reset wr_warn", wr_warn, 0);
    chk("R7", "reset ix_idx", ix_idx, 0);
    chk("R5", "reset pr_found", pr_found, 0);
    rst_n = 1;
    repeat (3) cyc("R7");

    // Populate
    wr("R6", 0, 'h00120, 'h0, 3, 0, 1, 'hAAAA0);
    wr("R6", 1, 'h00340, 'hF, 5, 0, 3, 'hBBBB1);
    wr("R6", 2, 'h00777, 'h0, 9, 1, 1, 'hCCCC2);
    wr("R6", 3, 'h00120, 'h0, 4, 0, 1, 'hDDDD3);
    wr("R6", 4, 'h00120, 'hF0, 3, 0, 1, 'hEEEE4);
    wr("R6", 5, 'h00555, 'h0, 1, 0, 2, 'h55555);
    wr("R6", 6, 'h00999, 'h0, 1, 0, 0, 'h66666);

    look("R1", 'h00120, 3);   // exact slot 0
    look("R1", 'h0034A, 5);   // masked slot 1
    look("R1", 'h00350, 5);   // masked bits outside: miss
    look("R2", 'h00777, 200); // global slot 2
    look("R2", 'h00120, 4);   // tag selects slot 3
    look("R2", 'h00120, 7);   // wrong tag: miss
    look("R3", 'h00120, 3);   // slots 0 and 4 overlap: 0
    look("R3", 'h00150, 3);   // only slot 4
    look("R4", 'h00555, 1);   // second valid bit only
    look("R4", 'h00999, 1);   // invalid slot: miss
    look("R5", 'h12345, 0);   // probe not found
    lk_valid = 0; pr_vpn = 20'h00777; cyc("R10"); // idle lookup, hold fields

    // Overwrite and out-of-range writes
    wr("R6", 0, 'h00121, 'h0, 3, 0, 1, 'h01010);
    look("R6", 'h00120, 3);   // now slot 4
    wr("R6", 16, 'h00888, 'h0, 0, 1, 3, 'h88888);
    look("R6", 'h00888, 0);
    wr("R6", 31, 'h00888, 'h0, 0, 1, 3, 'h88888);
    cyc("R6");

    // Replacement pointer with wrap
    for (int i = 0; i < 17; i++) begin ix_adv = 1; cyc("R9"); end
    ix_adv = 0; cyc("R9");

    // Uncacheable window
    uc_vaddr = 32'hA000_0000; cyc("R8");
    uc_vaddr = 32'hBFFF_FFFF; cyc("R8");
    uc_vaddr = 32'h8000_0000; cyc("R8");
    uc_vaddr = 32'h2FFF_FFFF; cyc("R8");

    // Flush together with a write and advance
    ix_adv = 1; flush = 1;
    wr("R7", 2, 'h00777, 'h0, 9, 1, 1, 'hCCCC2);
    flush = 0; ix_adv = 0;
    look("R7", 'h00777, 9);

    // Pseudo-random traffic against the model
    wr("R6", 7, 'h00040, 'h3, 2, 0, 1, 'h70707);
    wr("R6", 8, 'h00040, 'h0, 2, 0, 2, 'h80808);
    wr("R6", 9, 'h00041, 'h0, 0, 1, 3, 'h90909);
    lf = 32'h1ACE;
    for (int i = 0; i < 300; i++) begin
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
      lk_valid = lf[0]; lk_vpn = 20'h00040 + 20'(lf[3:1]); lk_asid = 8'(lf[5:4]);
      pr_vpn = 20'h00040 + 20'(lf[8:6]); pr_asid = 8'(lf[10:9]);
      ix_adv = lf[11]; uc_vaddr = {lf[15:0], lf[15:0]};
      cyc("R3");
    end
    lk_valid = 0; ix_adv = 0;
    cyc("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule